// File: doc/BRIEF.md
# CRC-16 Framed Data Packetizer

This block cuts a byte transfer of programmable total length into packets and frames them for a serial link. Each packet carries at most a configured power-of-two number of bytes. A start byte goes in front of each packet. When checksums are enabled, a CRC-16 over that packet's payload follows it. The same block also checks the receive direction. It drops filler bytes ahead of each packet start byte, forwards the payload, and checks each packet's trailing CRC.

Both directions use byte-wide valid/ready streams. A transfer begins with a one-cycle start pulse. On that edge the block captures the total length, the 3-bit packet-size code and the CRC enable. A one-cycle done pulse ends the transfer. Back-pressure rules: a producer that raises valid keeps valid and data steady until ready is seen high on a clock edge. A consumer may raise or drop ready in any cycle. In the payload phase the transmitter passes ready straight from its output to its input, and the receiver passes it from its payload output to its framed input. No byte is buffered inside the block.

Top module: `pkt_framer`

## Requirements
- R1: A packet holds 2^(LOG_MIN + code) bytes, where code is the 3-bit size code captured at start. Each packet carries the lesser of the remaining length and that size, so only the final packet may be short.
- R2: Each transmitted packet is preceded by one start byte. Its upper nibble is 0xF and its lower nibble is 1 for a first packet, 2 for an inner packet and 3 for the last packet. A transfer of a single packet is marked 3.
- R3: With CRC enabled, each packet's payload is followed by a CRC-16 sent high byte first. The CRC uses polynomial 0x1021, starts from 0xFFFF for every packet and uses no bit reflection. The payload bytes "123456789" give 0x29B1. With CRC disabled, no CRC bytes are sent.
- R4: A zero total length in either direction gives a done pulse in the cycle after start. No byte is emitted or consumed.
- R5: The transmit output keeps valid and data steady while not ready. A payload byte is taken from the input only in the cycle in which it is passed to the output.
- R6: The length, size code and CRC enable are sampled only on the start cycle. Changes to them during a transfer have no effect on either direction.
- R7: Busy is high from the cycle after start until done. Done is a single-cycle pulse in the cycle after the final byte handshake, and busy is low in that cycle.
- R8: On receive, any byte whose upper nibble is not 0xF, while a packet start is awaited, is consumed and dropped.
- R9: On receive, each packet's payload of the lesser of the remaining length and the packet size is forwarded to the payload stream. Then two CRC bytes are consumed when CRC is enabled.
- R10: On receive, an end-of-packet pulse marks every packet. A CRC mismatch raises the error flag together with that packet's end pulse only, and the transfer continues with the next packet.
- R11: After reset, both directions are idle, with no valid, ready, busy, done or error output high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_size_code | input | 3 | Packet size code, size = 2^(LOG_MIN+code) |
| cfg_crc_en | input | 1 | Append/check per-packet CRC-16 |
| xfer_len | input | LEN_W | Total transfer length in bytes |
| tx_start | input | 1 | Start a transmit transfer |
| tx_in_valid | input | 1 | Payload input valid |
| tx_in_data | input | 8 | Payload input byte |
| tx_in_ready | output | 1 | Payload input ready |
| tx_out_valid | output | 1 | Framed output valid |
| tx_out_data | output | 8 | Framed output byte |
| tx_out_ready | input | 1 | Framed output ready |
| tx_busy | output | 1 | Transmit transfer in progress |
| tx_done | output | 1 | Transmit transfer finished (pulse) |
| rx_start | input | 1 | Start a receive transfer |
| rx_in_valid | input | 1 | Framed input valid |
| rx_in_data | input | 8 | Framed input byte |
| rx_in_ready | output | 1 | Framed input ready |
| rx_pl_valid | output | 1 | Payload output valid |
| rx_pl_data | output | 8 | Payload output byte |
| rx_pl_ready | input | 1 | Payload output ready |
| rx_pkt_end | output | 1 | Received packet finished (pulse) |
| rx_crc_err | output | 1 | CRC mismatch on the finished packet (pulse) |
| rx_busy | output | 1 | Receive transfer in progress |
| rx_done | output | 1 | Receive transfer finished (pulse) |

## Verification
The bench builds the block with LOG_MIN = 2 and LEN_W = 12, so the size codes give packets of 4 to 512 bytes. With this setting, transfers of up to a few dozen bytes already split into many first, inner and last packets. Short final packets and exact multiples of the packet size are then swept exhaustively for codes 0 to 2, with CRC on and off, under random back-pressure. Code 7 is reached with a transfer of a few hundred bytes, and a fixed-vector run checks the CRC value itself. The receive sweep inserts filler bytes and corrupts one packet's CRC, to check error placement and continuation.

// File: rtl/pkt_framer_pkg.sv
package pkt_framer_pkg;

  localparam logic [3:0]  START_NIB  = 4'hF;
  localparam logic [3:0]  KIND_FIRST = 4'd1;
  localparam logic [3:0]  KIND_INNER = 4'd2;
  localparam logic [3:0]  KIND_LAST  = 4'd3;
  localparam logic [15:0] CRC_SEED   = 16'hFFFF;
  localparam logic [15:0] CRC_POLY   = 16'h1021;

  typedef enum logic [2:0] {
    TX_IDLE, TX_HDR, TX_PAY, TX_CRCH, TX_CRCL
  } tx_state_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_HUNT, RX_PAY, RX_CRCH, RX_CRCL
  } rx_state_t;

  // One byte of MSB-first CRC-16 update.
  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = (r << 1) ^ CRC_POLY;
      else              r = r << 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/pkt_seg_sel.sv
module pkt_seg_sel #(
  parameter int LEN_W   = 24,
  parameter int LOG_MIN = 8
) (
  input  logic [LEN_W-1:0] rem,
  input  logic [2:0]       code,
  output logic [LEN_W-1:0] seg_len,
  output logic             is_last
);
  localparam int SH_W = $clog2(LOG_MIN + 8);

  logic [LEN_W:0] size_full;
  logic [SH_W-1:0] shamt;

  assign shamt     = SH_W'(LOG_MIN) + SH_W'(code);
  assign size_full = {{LEN_W{1'b0}}, 1'b1} << shamt;
  assign is_last   = ({1'b0, rem} <= size_full);
  assign seg_len   = is_last ? rem : size_full[LEN_W-1:0];
endmodule

// File: rtl/pkt_tx_framer.sv
module pkt_tx_framer
  import pkt_framer_pkg::*;
#(
  parameter int LEN_W   = 24,
  parameter int LOG_MIN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic [2:0]       code,
  input  logic             crc_en,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  input  logic             out_ready,
  output logic             busy,
  output logic             done
);
  tx_state_t        st;
  logic [LEN_W-1:0] rem, cnt, seg_len;
  logic [2:0]       code_q;
  logic             crc_q, first_q, last_q, seg_last;
  logic [15:0]      crc;
  logic [3:0]       kind;

  pkt_seg_sel #(.LEN_W(LEN_W), .LOG_MIN(LOG_MIN)) seg_i (
    .rem(rem), .code(code_q), .seg_len(seg_len), .is_last(seg_last)
  );

  assign kind = seg_last ? KIND_LAST : (first_q ? KIND_FIRST : KIND_INNER);

  always_comb begin
    in_ready  = (st == TX_PAY) && out_ready;
    out_valid = 1'b0;
    out_data  = 8'h00;
    unique case (st)
      TX_HDR:  begin out_valid = 1'b1;     out_data = {START_NIB, kind}; end
      TX_PAY:  begin out_valid = in_valid; out_data = in_data;           end
      TX_CRCH: begin out_valid = 1'b1;     out_data = crc[15:8];         end
      TX_CRCL: begin out_valid = 1'b1;     out_data = crc[7:0];          end
      default: ;
    endcase
  end

  assign busy = (st != TX_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= TX_IDLE; rem <= '0; cnt <= '0; code_q <= '0; crc_q <= 1'b0;
      first_q <= 1'b0; last_q <= 1'b0; crc <= CRC_SEED; done <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        TX_IDLE: if (start) begin
          rem <= len; code_q <= code; crc_q <= crc_en; first_q <= 1'b1;
          if (len == '0) done <= 1'b1;
          else           st   <= TX_HDR;
        end
        TX_HDR: if (out_ready) begin
          cnt <= seg_len; last_q <= seg_last; first_q <= 1'b0;
          crc <= CRC_SEED; st <= TX_PAY;
        end
        TX_PAY: if (in_valid && out_ready) begin
          crc <= crc16_byte(crc, in_data);
          cnt <= cnt - 1'b1;
          rem <= rem - 1'b1;
          if (cnt == LEN_W'(1)) begin
            if (crc_q)       st <= TX_CRCH;
            else if (last_q) begin st <= TX_IDLE; done <= 1'b1; end
            else             st <= TX_HDR;
          end
        end
        TX_CRCH: if (out_ready) st <= TX_CRCL;
        TX_CRCL: if (out_ready) begin
          if (last_q) begin st <= TX_IDLE; done <= 1'b1; end
          else        st <= TX_HDR;
        end
        default: st <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pkt_rx_deframer.sv
module pkt_rx_deframer
  import pkt_framer_pkg::*;
#(
  parameter int LEN_W   = 24,
  parameter int LOG_MIN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic [2:0]       code,
  input  logic             crc_en,
  input  logic             src_valid,
  input  logic [7:0]       src_data,
  output logic             src_ready,
  output logic             pl_valid,
  output logic [7:0]       pl_data,
  input  logic             pl_ready,
  output logic             pkt_end,
  output logic             crc_err,
  output logic             busy,
  output logic             done
);
  rx_state_t        st;
  logic [LEN_W-1:0] rem, cnt, seg_len;
  logic [2:0]       code_q;
  logic             crc_q, last_q, seg_last;
  logic [15:0]      crc;
  logic [7:0]       crc_hi;

  pkt_seg_sel #(.LEN_W(LEN_W), .LOG_MIN(LOG_MIN)) seg_i (
    .rem(rem), .code(code_q), .seg_len(seg_len), .is_last(seg_last)
  );

  assign src_ready = (st == RX_HUNT) || (st == RX_CRCH) || (st == RX_CRCL) ||
                     ((st == RX_PAY) && pl_ready);
  assign pl_valid  = (st == RX_PAY) && src_valid;
  assign pl_data   = src_data;
  assign busy      = (st != RX_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RX_IDLE; rem <= '0; cnt <= '0; code_q <= '0; crc_q <= 1'b0;
      last_q <= 1'b0; crc <= CRC_SEED; crc_hi <= '0;
      pkt_end <= 1'b0; crc_err <= 1'b0; done <= 1'b0;
    end else begin
      pkt_end <= 1'b0; crc_err <= 1'b0; done <= 1'b0;
      unique case (st)
        RX_IDLE: if (start) begin
          rem <= len; code_q <= code; crc_q <= crc_en;
          if (len == '0) done <= 1'b1;
          else           st   <= RX_HUNT;
        end
        RX_HUNT: if (src_valid && src_data[7:4] == START_NIB) begin
          cnt <= seg_len; last_q <= seg_last; crc <= CRC_SEED; st <= RX_PAY;
        end
        RX_PAY: if (src_valid && pl_ready) begin
          crc <= crc16_byte(crc, src_data);
          cnt <= cnt - 1'b1;
          rem <= rem - 1'b1;
          if (cnt == LEN_W'(1)) begin
            if (crc_q) st <= RX_CRCH;
            else begin
              pkt_end <= 1'b1;
              if (last_q) begin st <= RX_IDLE; done <= 1'b1; end
              else        st <= RX_HUNT;
            end
          end
        end
        RX_CRCH: if (src_valid) begin crc_hi <= src_data; st <= RX_CRCL; end
        RX_CRCL: if (src_valid) begin
          pkt_end <= 1'b1;
          crc_err <= ({crc_hi, src_data} != crc);
          if (last_q) begin st <= RX_IDLE; done <= 1'b1; end
          else        st <= RX_HUNT;
        end
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pkt_framer.sv
module pkt_framer #(
  parameter int LEN_W   = 24,
  parameter int LOG_MIN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cfg_size_code,
  input  logic             cfg_crc_en,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic             tx_start,
  input  logic             tx_in_valid,
  input  logic [7:0]       tx_in_data,
  output logic             tx_in_ready,
  output logic             tx_out_valid,
  output logic [7:0]       tx_out_data,
  input  logic             tx_out_ready,
  output logic             tx_busy,
  output logic             tx_done,
  input  logic             rx_start,
  input  logic             rx_in_valid,
  input  logic [7:0]       rx_in_data,
  output logic             rx_in_ready,
  output logic             rx_pl_valid,
  output logic [7:0]       rx_pl_data,
  input  logic             rx_pl_ready,
  output logic             rx_pkt_end,
  output logic             rx_crc_err,
  output logic             rx_busy,
  output logic             rx_done
);
  pkt_tx_framer #(.LEN_W(LEN_W), .LOG_MIN(LOG_MIN)) tx_i (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .len(xfer_len),
    .code(cfg_size_code), .crc_en(cfg_crc_en),
    .in_valid(tx_in_valid), .in_data(tx_in_data), .in_ready(tx_in_ready),
    .out_valid(tx_out_valid), .out_data(tx_out_data), .out_ready(tx_out_ready),
    .busy(tx_busy), .done(tx_done)
  );

  pkt_rx_deframer #(.LEN_W(LEN_W), .LOG_MIN(LOG_MIN)) rx_i (
    .clk(clk), .rst_n(rst_n), .start(rx_start), .len(xfer_len),
    .code(cfg_size_code), .crc_en(cfg_crc_en),
    .src_valid(rx_in_valid), .src_data(rx_in_data), .src_ready(rx_in_ready),
    .pl_valid(rx_pl_valid), .pl_data(rx_pl_data), .pl_ready(rx_pl_ready),
    .pkt_end(rx_pkt_end), .crc_err(rx_crc_err),
    .busy(rx_busy), .done(rx_done)
  );
endmodule

// File: rtl/pkt_framer_chk.sv
module pkt_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_in_ready,
  input logic       tx_out_valid,
  input logic [7:0] tx_out_data,
  input logic       tx_out_ready,
  input logic       tx_busy,
  input logic       tx_done,
  input logic       rx_pl_valid,
  input logic [7:0] rx_pl_data,
  input logic       rx_pl_ready,
  input logic       rx_pkt_end,
  input logic       rx_crc_err,
  input logic       rx_busy,
  input logic       rx_done
);
  assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid && !tx_out_ready |=> tx_out_valid && $stable(tx_out_data));

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> !tx_in_ready && !tx_out_valid);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done |-> !tx_busy) and (rx_done |-> !rx_busy));

  assert_pl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pl_valid && !rx_pl_ready |=> rx_pl_valid && $stable(rx_pl_data));

  assert_err_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_crc_err |-> rx_pkt_end);
endmodule

bind pkt_framer pkt_framer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tx_in_ready(tx_in_ready),
  .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data),
  .tx_out_ready(tx_out_ready), .tx_busy(tx_busy), .tx_done(tx_done),
  .rx_pl_valid(rx_pl_valid), .rx_pl_data(rx_pl_data),
  .rx_pl_ready(rx_pl_ready), .rx_pkt_end(rx_pkt_end),
  .rx_crc_err(rx_crc_err), .rx_busy(rx_busy), .rx_done(rx_done)
);

// File: tb/pkt_framer_tb.sv
module pkt_framer_tb_top;
  localparam int LW = 12;
  localparam int LMIN = 2;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cfg_size_code = '0;
  logic cfg_crc_en = 1'b0;
  logic [LW-1:0] xfer_len = '0;
  logic tx_start = 0, tx_in_valid = 0, tx_out_ready = 0;
  logic [7:0] tx_in_data = '0;
  logic tx_in_ready, tx_out_valid, tx_busy, tx_done;
  logic [7:0] tx_out_data;
  logic rx_start = 0, rx_in_valid = 0, rx_pl_ready = 0;
  logic [7:0] rx_in_data = '0;
  logic rx_in_ready, rx_pl_valid, rx_pkt_end, rx_crc_err, rx_busy, rx_done;
  logic [7:0] rx_pl_data;

  int total = 0, bad = 0, cycles = 0;
  logic [7:0] fr [0:1023];
  int tag [0:1023];
  int n_fr, n_pkt;
  logic [7:0] got [0:1023];

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_framer #(.LEN_W(LW), .LOG_MIN(LMIN)) dut_i (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      check(1'b0, "watchdog", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [7:0] pay(input int i, input int len, input int mode);
    if (mode == 1) return 8'(8'h31 + i);
    return 8'(i * 13 + len * 5 + 1);
  endfunction

  function automatic logic [15:0] crc_of(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int b = 7; b >= 0; b--) begin
      logic fb = r[15] ^ d[b];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  // tags: 0 filler, 1 payload (R1), 2 header (R2), 3 crc (R3)
  task automatic build(input int len, input int code, input int crc, input int mode,
                       input int lead, input int corrupt);
    int size = 1 << (LMIN + code);
    int pos = 0, p = 0;
    n_fr = 0;
    n_pkt = (len + size - 1) / size;
    while (pos < len) begin
      int seg = (len - pos < size) ? len - pos : size;
      logic [15:0] c = 16'hFFFF;
      int kind = (pos + seg == len) ? 3 : (p == 0 ? 1 : 2);
      for (int k = 0; k < lead; k++) begin
        fr[n_fr] = (k % 2 == 1) ? 8'hC3 : 8'h00; tag[n_fr] = 0; n_fr++;
      end
      fr[n_fr] = {4'hF, 4'(kind)}; tag[n_fr] = 2; n_fr++;
      for (int k = 0; k < seg; k++) begin
        fr[n_fr] = pay(pos + k, len, mode); tag[n_fr] = 1;
        c = crc_of(c, fr[n_fr]); n_fr++;
      end
      if (crc != 0) begin
        fr[n_fr] = c[15:8]; tag[n_fr] = 3; n_fr++;
        fr[n_fr] = c[7:0] ^ ((p == corrupt) ? 8'h01 : 8'h00); tag[n_fr] = 3; n_fr++;
      end
      pos += seg; p++;
    end
  endtask

  task automatic run_tx(input int len, input int code, input int crc, input int mode);
    int in_i = 0, out_i = 0, cyc = 0;
    bit fin = 0;
    build(len, code, crc, mode, 0, -1);
    @(negedge clk);
    cfg_size_code = 3'(code); cfg_crc_en = crc[0]; xfer_len = LW'(len); tx_start = 1;
    @(negedge clk);
    tx_start = 0; cfg_size_code = 3'($urandom); cfg_crc_en = 1'($urandom); xfer_len = LW'($urandom);
    while (!fin && cyc < 4000) begin
      bit hs = 0;
      if (!tx_in_valid && in_i < len && ($urandom % 4 != 0)) begin
        tx_in_valid = 1; tx_in_data = pay(in_i, len, mode);
      end
      tx_out_ready = ($urandom % 4 != 0);
      #1;
      if (tx_in_valid && tx_in_ready) begin in_i++; hs = 1; end
      if (tx_out_valid && tx_out_ready) begin
        if (out_i < n_fr) begin
          got[out_i] = tx_out_data;
          if (tx_out_data !== fr[out_i])
            check(0, tag[out_i] == 2 ? "R2 header" : (tag[out_i] == 3 ? "R3 crc" : "R1 payload"),
                  tx_out_data, fr[out_i]);
          else total++;
        end else check(0, "R1 extra byte", tx_out_data, 0);
        out_i++;
      end
      if (tx_done) fin = 1;
      else if (!tx_busy) check(0, "R7 busy low mid-transfer", 0, 1);
      @(negedge clk);
      if (hs) tx_in_valid = 0;
      cyc++;
    end
    tx_out_ready = 0; tx_in_valid = 0;
    check(fin, "R7 done seen", fin, 1);
    check(out_i == n_fr, "R1 frame length", out_i, n_fr);
    check(in_i == len, "R5 bytes consumed", in_i, len);
    if (len == 0) check(cyc == 1, "R4 zero length done", cyc, 1);
  endtask

  task automatic run_rx(input int len, input int code, input int crc, input int lead,
                        input int corrupt);
    int src_i = 0, pl_i = 0, ends = 0, errs = 0, cyc = 0;
    bit fin = 0;
    build(len, code, crc, 0, lead, corrupt);
    @(negedge clk);
    cfg_size_code = 3'(code); cfg_crc_en = crc[0]; xfer_len = LW'(len); rx_start = 1;
    @(negedge clk);
    rx_start = 0; cfg_size_code = 3'($urandom); cfg_crc_en = 1'($urandom); xfer_len = LW'($urandom);
    while (!fin && cyc < 4000) begin
      bit hs = 0;
      if (!rx_in_valid && src_i < n_fr && ($urandom % 4 != 0)) begin
        rx_in_valid = 1; rx_in_data = fr[src_i];
      end
      rx_pl_ready = ($urandom % 4 != 0);
      #1;
      if (rx_in_valid && rx_in_ready) begin src_i++; hs = 1; end
      if (rx_pl_valid && rx_pl_ready) begin
        check(rx_pl_data === pay(pl_i, len, 0), "R9 payload", rx_pl_data, pay(pl_i, len, 0));
        pl_i++;
      end
      if (rx_pkt_end) begin
        if (rx_crc_err) begin
          errs++;
          check(crc != 0 && ends == corrupt, "R10 error packet", ends, corrupt);
        end
        ends++;
      end
      if (rx_done) fin = 1;
      @(negedge clk);
      if (hs) rx_in_valid = 0;
      cyc++;
    end
    rx_pl_ready = 0; rx_in_valid = 0;
    check(fin, "R4 rx done seen", fin, 1);
    check(src_i == n_fr, "R8 framed bytes consumed", src_i, n_fr);
    check(pl_i == len, "R9 payload count", pl_i, len);
    check(ends == n_pkt, "R10 packet ends", ends, n_pkt);
    check(errs == ((crc != 0 && corrupt >= 0 && corrupt < n_pkt) ? 1 : 0), "R10 error count",
          errs, (crc != 0 && corrupt >= 0) ? 1 : 0);
    if (len == 0) check(cyc == 1, "R4 rx zero length", cyc, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check(!tx_out_valid && !tx_in_ready && !tx_busy && !tx_done, "R11 tx reset", tx_busy, 0);
    check(!rx_in_ready && !rx_pl_valid && !rx_busy && !rx_done && !rx_pkt_end && !rx_crc_err,
          "R11 rx reset", rx_busy, 0);

    // R1 R2 R3 R5 R6 R7: near-exhaustive transmit sweep
    for (int crc = 0; crc < 2; crc++)
      for (int code = 0; code < 3; code++)
        for (int len = 0; len <= 40; len++)
          run_tx(len, code, crc, 0);
    run_tx(520, 7, 1, 0);
    run_tx(512, 7, 0, 0);

    // R3 known vector, size 16 single packet: header, 9 bytes, crc hi/lo
    run_tx(9, 2, 1, 1);
    check(got[10] == 8'h29, "R3 vector high byte", got[10], 8'h29);
    check(got[11] == 8'hB1, "R3 vector low byte", got[11], 8'hB1);
    check(got[0] == 8'hF3, "R2 single packet marked last", got[0], 8'hF3);

    // R8 R9 R10: receive sweep with filler bytes and one corrupted CRC
    for (int crc = 0; crc < 2; crc++)
      for (int code = 0; code < 3; code++)
        for (int len = 0; len <= 30; len++) begin
          int np = (len + (1 << (LMIN + code)) - 1) / (1 << (LMIN + code));
          run_rx(len, code, crc, len % 3, (len % 2 == 1 && np > 0) ? (len / 3) % np : -1);
        end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule